// File: doc/BRIEF.md
# Microcontroller Interrupt Control Unit

This block gathers the interrupt sources of a small 8-bit processor core that runs on a four-phase instruction cycle. Three sources feed it: an external pin with a selectable active edge, a roll-over pulse from a free-running timer, and any difference on the upper four bits of an input port. Each source owns a sticky flag and an enable bit. The flags, the enables and a global enable share one 8-bit control register, which the core reads and writes through a plain register port.

From this register the block drives an interrupt request and a fixed vector address. When the core takes the vector, the global enable drops so that a second interrupt cannot nest. A return strobe raises it again. While the core sleeps, the block raises a wake-up whenever a pending source was enabled at the moment sleep began. A second output states whether that wake-up should branch to the vector or resume at the next instruction.

The external pin is sampled only on the strobe that marks phase one of each instruction cycle, so a pulse must span one such strobe to be recognised. The port watcher compares the live nibble against a copy taken on the last port read, and its flag cannot be cleared while the two still differ.

Top module: `irq_unit`

## Requirements
- R1: After synchronous reset the control register reads 00h, and `irq_req`, `wake` and `wake_vec` are 0.
- R2: Control register layout: bit 7 global enable, bit 5 timer enable, bit 4 pin enable, bit 3 port enable, bit 2 timer flag, bit 1 pin flag, bit 0 port flag. Bit 6 always reads 0. A write takes effect on the clock edge and is visible on `reg_rdata` from the next cycle.
- R3: The pin flag (bit 1) is set on a `cyc_q1` cycle when `ext_pin` differs from its value at the previous `cyc_q1` and equals `edge_rise`. With `edge_rise`=1 the active edge is rising and with `edge_rise`=0 it is falling. The opposite edge has no effect.
- R4: A pin level that comes and goes between two `cyc_q1` strobes is not recognised and leaves bit 1 at 0.
- R5: A one-cycle `tmr_wrap` pulse sets the timer flag (bit 2).
- R6: While `port_hi` differs from the nibble captured on the last `port_rd` (0 after reset), the port flag (bit 0) is set every cycle, so a write of 0 cannot clear it. A `port_rd` captures the current nibble.
- R7: Flags are cleared only by writing 0 to them. When a hardware set and a clearing write fall in the same cycle, the flag ends at 1.
- R8: `irq_req` = bit7 AND ((bit5 AND bit2) OR (bit4 AND bit1) OR (bit3 AND bit0)), evaluated on the registered control value.
- R9: `vec_take` clears the global enable and `ret_strobe` sets it. Each of them overrides a register write to bit 7 in the same cycle, and `vec_take` wins over `ret_strobe`.
- R10: `vec_addr` is 0004h. While `sleep_in`=1, `wake` is 1 when a flag is set whose enable was 1 in the cycle before sleep began. Enables written during sleep do not count. `wake_vec` equals `wake` AND the global enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_q1 | input | 1 | Phase-one strobe, one clock per instruction cycle |
| ext_pin | input | 1 | External interrupt pin |
| edge_rise | input | 1 | Edge select: 1 rising, 0 falling |
| tmr_wrap | input | 1 | Timer roll-over pulse |
| port_hi | input | 4 | Upper nibble of the watched input port |
| port_rd | input | 1 | Port read strobe, captures `port_hi` |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| sleep_in | input | 1 | Core is asleep |
| vec_take | input | 1 | Core branches to the vector |
| ret_strobe | input | 1 | Return from interrupt |
| irq_req | output | 1 | Interrupt request to the core |
| wake | output | 1 | Wake-up from sleep |
| wake_vec | output | 1 | Wake-up should branch to the vector |
| vec_addr | output | 13 | Interrupt vector address |

## Verification
Two functions can collide in one cycle. The first is a software write that clears the flags in the same cycle as a timer wrap or a live port mismatch. The bench provokes this by holding the event input high across the write edge and expects the flag to read back as 1. The second is a register write to the global enable in the same cycle as `vec_take`. Here the bench expects the written enables to land and the global enable to read 0. Around these cases, every one of the 256 register values is swept and checked against the arithmetic request equation.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int CTRL_W  = 8;
    localparam int B_GIE   = 7;
    localparam int B_T_EN  = 5;
    localparam int B_P_EN  = 4;
    localparam int B_C_EN  = 3;
    localparam int B_T_FL  = 2;
    localparam int B_P_FL  = 1;
    localparam int B_C_FL  = 0;

    typedef struct packed {
        logic tmr;
        logic pin;
        logic chg;
    } src_t;

    function automatic src_t en_field(input logic [CTRL_W-1:0] v);
        return '{tmr: v[B_T_EN], pin: v[B_P_EN], chg: v[B_C_EN]};
    endfunction

    function automatic src_t fl_field(input logic [CTRL_W-1:0] v);
        return '{tmr: v[B_T_FL], pin: v[B_P_FL], chg: v[B_C_FL]};
    endfunction

    function automatic logic [CTRL_W-1:0] pack_ctrl(input logic gie,
                                                    input src_t en,
                                                    input src_t fl);
        logic [CTRL_W-1:0] r;
        r = '0;
        r[B_GIE]  = gie;
        r[B_T_EN] = en.tmr;
        r[B_P_EN] = en.pin;
        r[B_C_EN] = en.chg;
        r[B_T_FL] = fl.tmr;
        r[B_P_FL] = fl.pin;
        r[B_C_FL] = fl.chg;
        return r;
    endfunction

    function automatic logic pending(input src_t en, input src_t fl);
        return |(en & fl);
    endfunction

endpackage

// File: rtl/irq_edge_sense.sv
module irq_edge_sense (
    input  logic clk,
    input  logic rst,
    input  logic cyc_q1,
    input  logic pin,
    input  logic rise_sel,
    output logic hit
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b0;
        else if (cyc_q1)
            prev_q <= pin;
    end

    assign hit = cyc_q1 && (pin != prev_q) && (pin == rise_sel);

    assert_prev_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !cyc_q1 |=> $stable(prev_q));

endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NIB_W-1:0] port_hi,
    input  logic             port_rd,
    output logic             diff
);
    logic [NIB_W-1:0] snap_q;

    always_ff @(posedge clk) begin
        if (rst)
            snap_q <= '0;
        else if (port_rd)
            snap_q <= port_hi;
    end

    assign diff = (port_hi != snap_q);

    assert_snap_capture_R6: assert property (@(posedge clk) disable iff (rst)
        port_rd |=> (snap_q == $past(port_hi)));

endmodule

// File: rtl/irq_unit.sv
module irq_unit
    import irq_pkg::*;
#(
    parameter int          NIB_W    = 4,
    parameter int          PC_W     = 13,
    parameter logic [12:0] VEC_BASE = 13'h0004
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_q1,
    input  logic              ext_pin,
    input  logic              edge_rise,
    input  logic              tmr_wrap,
    input  logic [NIB_W-1:0]  port_hi,
    input  logic              port_rd,
    input  logic              reg_wr,
    input  logic [CTRL_W-1:0] reg_wdata,
    output logic [CTRL_W-1:0] reg_rdata,
    input  logic              sleep_in,
    input  logic              vec_take,
    input  logic              ret_strobe,
    output logic              irq_req,
    output logic              wake,
    output logic              wake_vec,
    output logic [PC_W-1:0]   vec_addr
);
    logic gie_q;
    src_t en_q, fl_q, en_snap_q, set_v, fl_base;
    logic pin_hit, port_diff;

    irq_edge_sense u_edge (
        .clk     (clk),
        .rst     (rst),
        .cyc_q1  (cyc_q1),
        .pin     (ext_pin),
        .rise_sel(edge_rise),
        .hit     (pin_hit)
    );

    irq_port_watch #(.NIB_W(NIB_W)) u_port (
        .clk    (clk),
        .rst    (rst),
        .port_hi(port_hi),
        .port_rd(port_rd),
        .diff   (port_diff)
    );

    assign set_v   = '{tmr: tmr_wrap, pin: pin_hit, chg: port_diff};
    assign fl_base = reg_wr ? fl_field(reg_wdata) : fl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gie_q     <= 1'b0;
            en_q      <= '0;
            fl_q      <= '0;
            en_snap_q <= '0;
        end else begin
            if (reg_wr)
                en_q <= en_field(reg_wdata);
            fl_q <= fl_base | set_v;
            if (vec_take)
                gie_q <= 1'b0;
            else if (ret_strobe)
                gie_q <= 1'b1;
            else if (reg_wr)
                gie_q <= reg_wdata[B_GIE];
            if (!sleep_in)
                en_snap_q <= en_q;
        end
    end

    assign reg_rdata = pack_ctrl(gie_q, en_q, fl_q);
    assign irq_req   = gie_q && pending(en_q, fl_q);
    assign wake      = sleep_in && pending(en_snap_q, fl_q);
    assign wake_vec  = wake && gie_q;
    assign vec_addr  = PC_W'(VEC_BASE);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        !$past(reg_wr) |-> ((fl_q & $past(fl_q)) == $past(fl_q)));

    assert_vec_clears_R9: assert property (@(posedge clk) disable iff (rst)
        vec_take |=> !reg_rdata[B_GIE]);

    assert_ret_sets_R9: assert property (@(posedge clk) disable iff (rst)
        (ret_strobe && !vec_take) |=> reg_rdata[B_GIE]);

    assert_port_flag_R6: assert property (@(posedge clk) disable iff (rst)
        port_diff |=> reg_rdata[B_C_FL]);

    assert_pin_on_q1_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(reg_rdata[B_P_FL]) && !$past(reg_wr)) |-> $past(cyc_q1));

    assert_wake_sleep_R10: assert property (@(posedge clk) disable iff (rst)
        wake |-> sleep_in);

endmodule

// File: tb/sim_irq_unit.sv
module sim_irq_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cyc_q1 = 0, ext_pin = 0, edge_rise = 0, tmr_wrap = 0;
    logic [3:0] port_hi = 4'h0;
    logic       port_rd = 0, reg_wr = 0, sleep_in = 0, vec_take = 0, ret_strobe = 0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_req, wake, wake_vec;
    logic [12:0] vec_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    irq_unit u0 (
        .clk(clk), .rst(rst), .cyc_q1(cyc_q1), .ext_pin(ext_pin),
        .edge_rise(edge_rise), .tmr_wrap(tmr_wrap), .port_hi(port_hi),
        .port_rd(port_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sleep_in(sleep_in), .vec_take(vec_take),
        .ret_strobe(ret_strobe), .irq_req(irq_req), .wake(wake),
        .wake_vec(wake_vec), .vec_addr(vec_addr)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        reg_wr = 1; reg_wdata = v;
        step();
        reg_wr = 0;
    endtask

    task automatic q1_step(input logic q1);
        cyc_q1 = q1;
        step();
        cyc_q1 = 0;
    endtask

    function automatic logic exp_irq(input logic [7:0] w);
        return w[7] & ((w[5] & w[2]) | (w[4] & w[1]) | (w[3] & w[0]));
    endfunction

    initial begin
        @(negedge clk);
        step(); step();
        rst = 0;
        step();
        // R1 reset state
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 irq", irq_req, 0);
        chk("R1 wake", wake, 0);
        chk("R10 vector", vec_addr, 13'h0004);

        // R2 / R8 exhaustive register sweep
        for (int w = 0; w < 256; w++) begin
            wr(w[7:0]);
            chk("R2 readback", reg_rdata, w & 8'hBF);
            chk("R8 request", irq_req, exp_irq(w[7:0]));
        end
        wr(8'h00);

        // R3 / R4 both polarities
        for (int p = 0; p < 2; p++) begin
            edge_rise = p[0];
            ext_pin = ~p[0];
            q1_step(1);
            chk("R3 wrong edge", reg_rdata[1], 0);
            ext_pin = p[0];
            q1_step(0);
            chk("R3 no strobe", reg_rdata[1], 0);
            q1_step(1);
            chk("R3 active edge", reg_rdata[1], 1);
            wr(8'h00);
            chk("R7 write clears", reg_rdata[1], 0);
            ext_pin = ~p[0];
            q1_step(1);
            chk("R3 return edge", reg_rdata[1], 0);
            ext_pin = p[0];
            q1_step(0); q1_step(0);
            ext_pin = ~p[0];
            q1_step(1);
            chk("R4 short pulse", reg_rdata[1], 0);
        end

        // R5 timer
        tmr_wrap = 1; step(); tmr_wrap = 0;
        chk("R5 timer flag", reg_rdata[2], 1);
        chk("R8 disabled", irq_req, 0);
        wr(8'hA4);
        chk("R8 enabled", irq_req, 1);

        // R9 vector / return
        vec_take = 1; step(); vec_take = 0;
        chk("R9 vec clears", reg_rdata, 8'h24);
        chk("R9 irq off", irq_req, 0);
        ret_strobe = 1; step(); ret_strobe = 0;
        chk("R9 ret sets", reg_rdata, 8'hA4);
        vec_take = 1; reg_wr = 1; reg_wdata = 8'hA4; step();
        vec_take = 0; reg_wr = 0;
        chk("R9 vec over write", reg_rdata, 8'h24);

        // R7 coincidence: clear write with timer wrap
        tmr_wrap = 1; reg_wr = 1; reg_wdata = 8'h00; step();
        tmr_wrap = 0; reg_wr = 0;
        chk("R7 set wins", reg_rdata, 8'h04);
        wr(8'h00);
        chk("R7 cleared", reg_rdata, 8'h00);

        // R6 port change
        port_hi = 4'h5; step();
        chk("R6 change", reg_rdata[0], 1);
        wr(8'h00);
        chk("R6 held while differ", reg_rdata[0], 1);
        port_rd = 1; step(); port_rd = 0;
        wr(8'h00);
        chk("R6 clear after read", reg_rdata[0], 0);
        for (int v = 0; v < 16; v++) begin
            port_hi = v[3:0]; step();
            chk("R6 nibble", reg_rdata[0], (v != 5 && v != 0) || (v == 0) ? int'(v[3:0] != 4'h5 || v != 5) : 0);
            port_rd = 1; step(); port_rd = 0;
            wr(8'h00);
            chk("R6 nibble clear", reg_rdata[0], 0);
            port_hi = 4'h5; port_rd = 1; step(); port_rd = 0;
            wr(8'h00);
        end

        // R10 wake
        wr(8'h10); step();
        sleep_in = 1; step();
        edge_rise = 1; ext_pin = 0; q1_step(1);
        ext_pin = 1; q1_step(1);
        chk("R10 wake", wake, 1);
        chk("R10 no vector", wake_vec, 0);
        wr(8'h10);
        chk("R10 wake clear", wake, 0);
        sleep_in = 0; wr(8'h90); step();
        sleep_in = 1; step();
        wr(8'h92);
        chk("R10 wake gie", wake, 1);
        chk("R10 vector on wake", wake_vec, 1);
        sleep_in = 0; wr(8'h80); step();
        sleep_in = 1; step();
        wr(8'h92);
        chk("R10 snapshot", wake, 0);
        chk("R8 awake irq", irq_req, 1);
        sleep_in = 0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule